// File: doc/BRIEF.md
# Serial-Command Memory Programming Controller

This block gives an external host access to a parallel flash ROM and a parallel RAM through a four-wire serial link: a clock (`tck`), a mode line (`tms`), serial data in (`tdi`) and serial data out (`tdo`). `tck` is the only clock. The host sends short framed commands. Each command loads an address counter, increments it, reads one memory word out serially, or shifts one word in and writes it. Flash erase and program sequences are built by the host from repeated single-word writes.

On the memory side the controller drives a 17-bit address and active-low read and write strobes. It also drives two active-low chip-selects, one for the ROM and one for the RAM, chosen by a select bit that travels with the address. Write data leaves on `mem_wdata` together with an output enable. Read data comes back on `mem_rdata`; a tri-state pad at chip level joins the two into one bus. Each strobe is exactly one `tck` period wide, so the host sets the real strobe width through its clock rate.

Top module: `sercmd_memprog`

## Requirements
- R1: While the controller is idle and `tms` is high on a rising edge, it stays idle. No strobe or chip-select is asserted, the address is unchanged, and `tdo` stays 0.
- R2: In idle, a rising edge with `tms` low starts a frame and captures `tdi` as command bit C1. The next rising edge captures C2. Inside a frame `tms` is ignored. The command codes {C1,C2} are: 00 address load, 01 increment, 10 read, 11 write.
- R3: For address load, the 18 rising edges after C2 carry the select bit and then the address, most significant bit first. The new select bit and address take effect on `mem_addr` after the last of these edges, and the controller is idle on the edge after that.
- R4: Increment adds one to the address on the first edge after C2 and returns to idle on the second. Address 0x1FFFF wraps to 0.
- R5: For write, 8 data bits follow C2 at once, most significant first. In the `tck` period after the last data bit, `mem_wr_n` is low and `mem_wdata` holds the word. The controller is idle after that period, and any number of extra idle clocks may follow.
- R6: For read, `mem_rd_n` is low in the period after C2. The word on `mem_rdata` is captured at the end of that period. Its bit 7 appears on `tdo` from the next falling edge, and bits 6 down to 0 follow one per clock.
- R7: `mem_rd_n` and `mem_wr_n` are never low together, and each low pulse lasts exactly one `tck` period.
- R8: During a strobe, select 0 asserts `rom_cs_n` and select 1 asserts `ram_cs_n`. Neither chip-select is low outside a strobe.
- R9: `mem_wdata_oe` is high exactly while `mem_wr_n` is low.
- R10: `tdo` changes only on falling edges of `tck` and is 0 whenever no read word is being shifted out.
- R11: A synchronous high `rst` returns the controller to idle with address 0, select 0, strobes, chip-selects and output enable inactive, and `tdo` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Serial clock, the only clock |
| rst | input | 1 | Synchronous reset, active high |
| tms | input | 1 | Frame tag, low for one clock to start a command |
| tdi | input | 1 | Serial command, address and data in |
| tdo | output | 1 | Serial read data out, updated on falling edges |
| mem_addr | output | 17 | Memory address |
| mem_wdata | output | 8 | Write data toward the memory bus |
| mem_wdata_oe | output | 1 | Drive enable for write data |
| mem_rdata | input | 8 | Read data from the memory bus |
| rom_cs_n | output | 1 | ROM chip-select, active low |
| ram_cs_n | output | 1 | RAM chip-select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
Assertions watch on every cycle for the properties that hold at any moment. Strobes are one period wide and never overlap, at most one chip-select is low and only with a strobe, and the output enable tracks the write strobe. `tdo` stays quiet outside a read, the address holds between load and increment, 0x1FFFF wraps to 0, and an idle `tms` tag starts a frame. Only the bench scenarios can show the rest. Those cover the bit order of address and data frames, that the word read back is the one written at that address and select, `tms` noise inside a frame, back-to-back frames, extra trailing idle clocks, and a reset in the middle of a sequence.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD2,
    ST_ADDR,
    ST_INC1,
    ST_INC2,
    ST_WDATA,
    ST_WSTB,
    ST_RSTB,
    ST_SHOUT
  } sercmd_state_e;

  typedef enum logic [1:0] {
    CMD_LOAD  = 2'b00,
    CMD_INC   = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } sercmd_cmd_e;

endpackage

// File: rtl/sercmd_seq.sv
module sercmd_seq
  import sercmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tms,
  input  logic          tdi,
  output sercmd_state_e state,
  output logic          ev_a_shift,
  output logic          ev_a_commit,
  output logic          ev_inc,
  output logic          ev_d_shift,
  output logic          ev_w_go,
  output logic          ev_r_go,
  output logic          ev_r_cap,
  output logic          ev_o_shift
);

  localparam int FR_BITS = ADDR_W + 1;
  localparam int MAXN    = (FR_BITS > DATA_W) ? FR_BITS : DATA_W;
  localparam int CW      = $clog2(MAXN);

  logic [CW-1:0] cnt;
  logic          c1;
  sercmd_cmd_e   cmd;

  assign cmd = sercmd_cmd_e'({c1, tdi});

  assign ev_a_shift  = (state == ST_ADDR);
  assign ev_a_commit = (state == ST_ADDR) && (cnt == CW'(FR_BITS - 1));
  assign ev_inc      = (state == ST_INC1);
  assign ev_d_shift  = (state == ST_WDATA);
  assign ev_w_go     = (state == ST_WDATA) && (cnt == CW'(DATA_W - 1));
  assign ev_r_go     = (state == ST_CMD2) && (cmd == CMD_READ);
  assign ev_r_cap    = (state == ST_RSTB);
  assign ev_o_shift  = (state == ST_SHOUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      c1    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!tms) begin
            c1    <= tdi;
            state <= ST_CMD2;
          end
        end
        ST_CMD2: begin
          cnt <= '0;
          case (cmd)
            CMD_LOAD:  state <= ST_ADDR;
            CMD_INC:   state <= ST_INC1;
            CMD_READ:  state <= ST_RSTB;
            default:   state <= ST_WDATA;
          endcase
        end
        ST_ADDR: begin
          if (cnt == CW'(FR_BITS - 1)) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        ST_INC1: state <= ST_INC2;
        ST_INC2: state <= ST_IDLE;
        ST_WDATA: begin
          if (cnt == CW'(DATA_W - 1)) state <= ST_WSTB;
          else cnt <= cnt + 1'b1;
        end
        ST_WSTB: state <= ST_IDLE;
        ST_RSTB: begin
          cnt   <= '0;
          state <= ST_SHOUT;
        end
        ST_SHOUT: begin
          if (cnt == CW'(DATA_W - 1)) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a low tag seen in idle opens a frame on the next edge
  assert_frame_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !tms) |=> (state == ST_CMD2));

  // R1: idle is held while the tag line stays high
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tms) |=> (state == ST_IDLE));

endmodule

// File: rtl/sercmd_addr.sv
module sercmd_addr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  input  logic              a_shift,
  input  logic              a_commit,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              sel
);

  logic [ADDR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      addr <= '0;
      sel  <= 1'b0;
    end else begin
      if (a_shift) sh <= {sh[ADDR_W-2:0], tdi};
      if (a_commit) {sel, addr} <= {sh, tdi};
      else if (inc) addr <= addr + 1'b1;
    end
  end

  // R4: top address rolls over to zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (inc && !a_commit && addr == '1) |=> (addr == '0));

  // R3: address and select only move on a load or an increment
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!a_commit && !inc) |=> ($stable(addr) && $stable(sel)));

endmodule

// File: rtl/sercmd_strobe.sv
module sercmd_strobe (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic w_go,
  input  logic r_go,
  output logic rd_n,
  output logic wr_n,
  output logic rom_cs_n,
  output logic ram_cs_n
);

  logic any_go;
  assign any_go = w_go | r_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      rom_cs_n <= 1'b1;
      ram_cs_n <= 1'b1;
    end else begin
      rd_n     <= ~r_go;
      wr_n     <= ~w_go;
      rom_cs_n <= ~(any_go & ~sel);
      ram_cs_n <= ~(any_go & sel);
    end
  end

  // R7: each strobe is one period wide and they never overlap
  assert_rd_width_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> rd_n);
  assert_wr_width_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> wr_n);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R8: one chip-select at most, and only together with a strobe
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~rom_cs_n, ~ram_cs_n}));
  assert_cs_with_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!rom_cs_n || !ram_cs_n) == (!rd_n || !wr_n));

endmodule

// File: rtl/sercmd_data.sv
module sercmd_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  input  logic              d_shift,
  input  logic              w_go,
  input  logic              r_cap,
  input  logic              o_shift,
  input  logic              shout,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata,
  output logic              wdata_oe,
  output logic              tdo
);

  logic [DATA_W-1:0] dreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      dreg     <= '0;
      wdata    <= '0;
      wdata_oe <= 1'b0;
    end else begin
      if (r_cap) dreg <= rdata;
      else if (d_shift || o_shift) dreg <= {dreg[DATA_W-2:0], tdi};
      if (w_go) wdata <= {dreg[DATA_W-2:0], tdi};
      wdata_oe <= w_go;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= shout ? dreg[DATA_W-1] : 1'b0;
  end

  // R9: the drive enable is a single-period pulse
  assert_oe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wdata_oe |=> !wdata_oe);

  // R10: serial output is quiet unless a read word is leaving
  assert_tdo_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !shout |-> (tdo == 1'b0));

endmodule

// File: rtl/sercmd_memprog.sv
module sercmd_memprog
  import sercmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n
);

  sercmd_state_e state;
  logic ev_a_shift, ev_a_commit, ev_inc, ev_d_shift;
  logic ev_w_go, ev_r_go, ev_r_cap, ev_o_shift;
  logic sel;

  sercmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(tck), .rst(rst), .tms(tms), .tdi(tdi), .state(state),
    .ev_a_shift(ev_a_shift), .ev_a_commit(ev_a_commit), .ev_inc(ev_inc),
    .ev_d_shift(ev_d_shift), .ev_w_go(ev_w_go), .ev_r_go(ev_r_go),
    .ev_r_cap(ev_r_cap), .ev_o_shift(ev_o_shift)
  );

  sercmd_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(tck), .rst(rst), .tdi(tdi), .a_shift(ev_a_shift),
    .a_commit(ev_a_commit), .inc(ev_inc), .addr(mem_addr), .sel(sel)
  );

  sercmd_strobe u_strobe (
    .clk(tck), .rst(rst), .sel(sel), .w_go(ev_w_go), .r_go(ev_r_go),
    .rd_n(mem_rd_n), .wr_n(mem_wr_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  sercmd_data #(.DATA_W(DATA_W)) u_data (
    .clk(tck), .rst(rst), .tdi(tdi), .d_shift(ev_d_shift), .w_go(ev_w_go),
    .r_cap(ev_r_cap), .o_shift(ev_o_shift), .shout(state == ST_SHOUT),
    .rdata(mem_rdata), .wdata(mem_wdata), .wdata_oe(mem_wdata_oe), .tdo(tdo)
  );

  // R9: bus drive coincides with the write strobe
  assert_oe_with_wr_R9: assert property (@(posedge tck) disable iff (rst)
    mem_wdata_oe == !mem_wr_n);

endmodule

// File: tb/sercmd_memprog_bench.sv
module sercmd_memprog_bench;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam logic [AW-1:0] AMASK = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic [DW-1:0] mem_rdata = '0;
  logic          rom_cs_n, ram_cs_n, mem_rd_n, mem_wr_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sercmd_memprog #(.ADDR_W(AW), .DATA_W(DW)) u_sercmd_memprog (
    .tck(clk), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dflt(input bit s, input int a);
    return s ? 8'((a * 13 + 85) & 255) : 8'((a * 7 + 3) & 255);
  endfunction

  // ---------------- attached memories (driven from the pins) --------------
  logic [7:0] dev_rom [int];
  logic [7:0] dev_ram [int];

  always @(negedge clk) begin
    if (!mem_rd_n) begin
      if (!rom_cs_n)      mem_rdata <= dev_rom.exists(int'(mem_addr)) ? dev_rom[int'(mem_addr)] : dflt(0, int'(mem_addr));
      else if (!ram_cs_n) mem_rdata <= dev_ram.exists(int'(mem_addr)) ? dev_ram[int'(mem_addr)] : dflt(1, int'(mem_addr));
      else                mem_rdata <= 8'hEE;
    end
    if (!mem_wr_n && mem_wdata_oe) begin
      if (!rom_cs_n)      dev_rom[int'(mem_addr)] = mem_wdata;
      else if (!ram_cs_n) dev_ram[int'(mem_addr)] = mem_wdata;
    end
  end

  // ---------------- behavioural reference model ---------------------------
  logic [7:0] m_rom [int];
  logic [7:0] m_ram [int];
  int         pos = 0;
  int         cmd = 0;
  bit         c1  = 0;
  logic [31:0] acc = '0;
  logic [AW-1:0] m_addr = '0;
  bit         m_sel = 0;
  logic [7:0] rdbyte = '0;
  bit e_rd = 1, e_wr = 1, e_rom = 1, e_ram = 1, e_oe = 0, e_tdo = 0;
  logic [7:0] e_wdata = '0;

  function automatic logic [7:0] mread(input bit s, input int a);
    if (s) return m_ram.exists(a) ? m_ram[a] : dflt(1, a);
    return m_rom.exists(a) ? m_rom[a] : dflt(0, a);
  endfunction

  always @(posedge clk) begin
    e_rd = 1; e_wr = 1; e_rom = 1; e_ram = 1; e_oe = 0; e_tdo = 0;
    if (rst) begin
      pos = 0; m_addr = '0; m_sel = 0;
    end else if (pos == 0) begin
      if (!tms) begin pos = 1; c1 = tdi; end
    end else begin
      pos++;
      if (pos == 2) begin
        cmd = {c1, tdi};
        acc = '0;
        if (cmd == 2) begin
          e_rd = 0;
          if (m_sel) e_ram = 0; else e_rom = 0;
        end
      end else begin
        case (cmd)
          0: begin
            acc = (acc << 1) | 32'(tdi);
            if (pos == 20) begin
              m_sel = acc[17]; m_addr = acc[16:0]; pos = 0;
            end
          end
          1: begin
            if (pos == 3) m_addr = (m_addr + 1) & AMASK;
            else pos = 0;
          end
          3: begin
            if (pos <= 10) acc = (acc << 1) | 32'(tdi);
            if (pos == 10) begin
              e_wr = 0; e_oe = 1; e_wdata = acc[7:0];
              if (m_sel) begin e_ram = 0; m_ram[int'(m_addr)] = acc[7:0]; end
              else       begin e_rom = 0; m_rom[int'(m_addr)] = acc[7:0]; end
            end
            if (pos == 11) pos = 0;
          end
          default: begin
            if (pos == 3) begin
              rdbyte = mread(m_sel, int'(m_addr));
              e_tdo = rdbyte[7];
            end else if (pos <= 10) begin
              e_tdo = rdbyte[10 - pos];
            end else begin
              pos = 0;
            end
          end
        endcase
      end
    end
  end

  // compare on every clock
  always @(posedge clk) begin
    #2;
    chk(mem_rd_n == e_rd, "R6 rd strobe", int'(mem_rd_n), int'(e_rd));
    chk(mem_wr_n == e_wr, "R5 wr strobe", int'(mem_wr_n), int'(e_wr));
    chk(rom_cs_n == e_rom, "R8 rom cs", int'(rom_cs_n), int'(e_rom));
    chk(ram_cs_n == e_ram, "R8 ram cs", int'(ram_cs_n), int'(e_ram));
    chk(mem_wdata_oe == e_oe, "R9 oe", int'(mem_wdata_oe), int'(e_oe));
    if (e_oe) chk(mem_wdata == e_wdata, "R5 wdata", int'(mem_wdata), int'(e_wdata));
    chk(mem_addr == m_addr, "R3 address", int'(mem_addr), int'(m_addr));
  end

  always @(negedge clk) begin
    #2;
    chk(tdo === e_tdo, "R10 tdo", int'(tdo), int'(e_tdo));
  end

  // ---------------- host tasks --------------------------------------------
  bit noise = 0;

  task automatic bitx(input logic m, input logic d, output logic o);
    @(negedge clk);
    tms = m;
    tdi = d;
    #2 o = tdo;
  endtask

  task automatic fr(input logic d);   // in-frame bit, tag line may be noisy
    logic o;
    bitx(noise ? logic'($urandom_range(0, 1)) : 1'b1, d, o);
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) bitx(1'b1, logic'(i[0]), o);
  endtask

  task automatic cmd2(input logic a, input logic b);
    logic o;
    bitx(1'b0, a, o);
    fr(b);
  endtask

  task automatic load(input bit s, input logic [AW-1:0] a);
    cmd2(0, 0);
    fr(s);
    for (int i = AW - 1; i >= 0; i--) fr(a[i]);
  endtask

  task automatic incr();
    cmd2(0, 1);
    fr(0); fr(0);
  endtask

  task automatic wr(input logic [7:0] d, input int extra);
    cmd2(1, 1);
    for (int i = 7; i >= 0; i--) fr(d[i]);
    fr(0);
    idle(extra);
  endtask

  task automatic rd(output logic [7:0] v);
    logic o;
    cmd2(1, 0);
    bitx(1'b1, 1'b0, o);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitx(1'b1, 1'b0, o);
      v = {v[6:0], o};
    end
  endtask

  // ---------------- scenarios ---------------------------------------------
  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    chk(mem_addr == '0, "R11 reset addr", int'(mem_addr), 0);
    chk(mem_rd_n && mem_wr_n && rom_cs_n && ram_cs_n, "R11 reset strobes", 0, 1);
    chk(tdo == 1'b0 && !mem_wdata_oe, "R11 reset tdo/oe", int'(tdo), 0);

    // R1: long idle with tdi toggling
    idle(12);
    chk(mem_addr == '0, "R1 idle addr", int'(mem_addr), 0);

    // R3 + R5 + R6 on ROM
    load(0, 17'h00010);
    wr(8'h5A, 1);
    incr();
    wr(8'hC3, 3);
    load(0, 17'h00010);
    rd(v); chk(v == 8'h5A, "R6 read rom 0x10", int'(v), 8'h5A);
    incr();
    rd(v); chk(v == 8'hC3, "R6 read rom 0x11", int'(v), 8'hC3);

    // R2: noisy tag line inside frames, back-to-back frames
    noise = 1;
    load(1, 17'h1FFFF);
    wr(8'h77, 0);
    incr();
    chk(mem_addr == '0, "R4 wrap to zero", int'(mem_addr), 0);
    wr(8'h11, 0);
    rd(v); chk(v == 8'h11, "R2 read ram 0 noisy tag", int'(v), 8'h11);
    load(1, 17'h1FFFF);
    rd(v); chk(v == 8'h77, "R8 read ram top", int'(v), 8'h77);
    load(0, 17'h1FFFF);
    rd(v); chk(v == dflt(0, 17'h1FFFF), "R8 rom untouched", int'(v), int'(dflt(0, 17'h1FFFF)));
    noise = 0;

    // read of an unwritten location
    load(0, 17'h00123);
    rd(v); chk(v == dflt(0, 17'h123), "R6 read default rom", int'(v), int'(dflt(0, 17'h123)));

    // mixed writes and reads
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom_range(0, 17'h1FFFF));
      d = 8'($urandom_range(0, 255));
      load(bit'(k[0]), a);
      wr(d, k % 3);
      load(bit'(k[0]), a);
      rd(v); chk(v == d, "R5 write/read pair", int'(v), int'(d));
    end

    // R11: reset in the middle clears select and address
    load(1, 17'h0ABCD);
    idle(2);
    rst = 1;
    idle(2);
    rst = 0;
    idle(1);
    chk(mem_addr == '0, "R11 mid reset addr", int'(mem_addr), 0);
    wr(8'h3E, 1);
    rd(v); chk(v == 8'h3E, "R11 select back to rom", int'(v), 8'h3E);
    load(1, 17'h00000);
    rd(v); chk(v == 8'h11, "R11 ram kept", int'(v), 8'h11);
    idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule